// File: doc/BRIEF.md
# Double-Buffered Dual DAC Register Interface

This block is the digital register core of a two-channel current-output converter whose output range is programmable. Each channel holds a staging pair (a 16-bit code and a 3-bit range code) that a host fills over a shared bidirectional parallel bus. It also holds an active pair that drives the converter. A separate update strobe copies staging into active, so both channels can be changed together. The same strobe line, while the read line is high, instead chooses which of the two pairs is returned on the bus.

Bus strobes are sampled on a system clock and act on their rising edges. The write strobe acts where it returns high, and the update strobe acts where it goes high. An active-low clear input takes effect at once on the code outputs. It forces the code that gives zero volts in the channel's current range: mid-scale for symmetric bipolar ranges, quarter-scale for the offset range, and zero for unipolar ranges. While clear stays low, the next clock edges load that code into both registers of each channel. A strap input fixes the range of both channels and hides the range registers from the bus.

Top module: `dual_dac_regs`

## Requirements
- R1: After reset (rst_n low), all codes and range registers are 0, so both code outputs read 0x0000 and both range outputs read 000.
- R2: The write strobe acts where wr_n, sampled high, was low at the previous edge, with rd low. It loads data_io (sel_span=0) or span_io (sel_span=1) into the staging register of the addressed channels. addr 00 selects A, 01 selects B, 1x selects both. The active outputs do not change.
- R3: A write strobe while rd is high changes no register.
- R4: An update strobe (upd rising, rd low) copies staging code and range together into the active registers of the addressed channels. It uses the same address map as writes.
- R5: With rd high, upd is not an update: upd=0 reads staging, upd=1 reads active. addr 01 returns B and every other address returns A.
- R6: data_io and span_io are high impedance whenever rd is low.
- R7: Range codes are 000 0..5V, 001 0..10V, 010 +/-5V, 011 +/-10V, 100 +/-2.5V, 101 -2.5..7.5V. Codes 110 and 111 act as 000 on the range outputs.
- R8: While clr_n is low, each code output shows the zero-volt code of its active range without waiting for a clock: 0x0000 for 000/001, 0x8000 for 010/011/100, 0x4000 for 101.
- R9: Each clock edge with clr_n low loads that zero code into both the staging and active code registers of both channels. Writes and updates on that edge are ignored, and range registers keep their values.
- R10: When strap_en is 1, both range outputs show strap_span (normalised as in R7). span_io is never driven, and range writes are ignored.
- R11: A write and an update on the same edge to the same channel pass the newly written value straight into the active register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Active-low clear to zero volts |
| wr_n | input | 1 | Active-low write strobe |
| upd | input | 1 | Update strobe / readback bank select |
| rd | input | 1 | Readback enable |
| sel_span | input | 1 | Write target: 0 code, 1 range |
| addr | input | 2 | Channel address |
| strap_en | input | 1 | Fixed-range mode enable |
| strap_span | input | 3 | Fixed range code |
| data_io | inout | 16 | Bidirectional code bus |
| span_io | inout | 3 | Bidirectional range bus |
| code_a | output | 16 | Active code, channel A |
| code_b | output | 16 | Active code, channel B |
| span_a | output | 3 | Active range, channel A |
| span_b | output | 3 | Active range, channel B |

## Verification
Two actions can meet on one clock edge. A write and an update to the same channel can coincide, and so can a clear and an update. The bench raises the update line in the same cycle that the write strobe returns high. In other cases it holds clear low across an update edge. It then judges the result by the active outputs, and by reading back both banks, against a reference model. In that model the write value is passed forward, and clear blocks the update but keeps the range. Random traffic mixes both collisions with ordinary writes, reads and blocked writes.

// File: rtl/dual_dac_regs.sv
module dual_dac_regs #(
  parameter int DW = 16,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          wr_n,
  input  logic          upd,
  input  logic          rd,
  input  logic          sel_span,
  input  logic [1:0]    addr,
  input  logic          strap_en,
  input  logic [SW-1:0] strap_span,
  inout  wire  [DW-1:0] data_io,
  inout  wire  [SW-1:0] span_io,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b,
  output logic [SW-1:0] span_a,
  output logic [SW-1:0] span_b
);
  localparam logic [SW-1:0] LAST_SPAN = SW'(5);

  function automatic logic [SW-1:0] norm(input logic [SW-1:0] s);
    return (s > LAST_SPAN) ? '0 : s;
  endfunction

  function automatic logic [DW-1:0] zcode(input logic [SW-1:0] s);
    logic [DW-1:0] z;
    z = '0;
    case (s)
      SW'(2), SW'(3), SW'(4): z[DW-1] = 1'b1;
      SW'(5):                 z[DW-2] = 1'b1;
      default:                z = '0;
    endcase
    return z;
  endfunction

  logic [1:0][DW-1:0] in_code, dac_code, in_code_n;
  logic [1:0][SW-1:0] in_span, dac_span, in_span_n, act;
  logic [1:0]         hit;
  logic               wr_q, upd_q;

  wire wr_go  = !wr_q && wr_n && !rd && clr_n;
  wire upd_go = !upd_q && upd && !rd && clr_n;

  assign hit[0] = (addr != 2'b01);
  assign hit[1] = (addr != 2'b00);

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      act[c]       = strap_en ? norm(strap_span) : norm(dac_span[c]);
      in_code_n[c] = (wr_go && hit[c] && !sel_span) ? data_io : in_code[c];
      in_span_n[c] = (wr_go && hit[c] && sel_span && !strap_en) ? span_io : in_span[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b1;
      upd_q    <= 1'b1;
      in_code  <= '0;
      dac_code <= '0;
      in_span  <= '0;
      dac_span <= '0;
    end else begin
      wr_q  <= wr_n;
      upd_q <= upd;
      for (int c = 0; c < 2; c++) begin
        if (!clr_n) begin
          in_code[c]  <= zcode(act[c]);
          dac_code[c] <= zcode(act[c]);
        end else begin
          in_code[c] <= in_code_n[c];
          in_span[c] <= in_span_n[c];
          if (upd_go && hit[c]) begin
            dac_code[c] <= in_code_n[c];
            dac_span[c] <= in_span_n[c];
          end
        end
      end
    end
  end

  assign code_a = clr_n ? dac_code[0] : zcode(act[0]);
  assign code_b = clr_n ? dac_code[1] : zcode(act[1]);
  assign span_a = act[0];
  assign span_b = act[1];

  wire rsel = (addr == 2'b01);
  assign data_io = rd ? (upd ? dac_code[rsel] : in_code[rsel]) : 'z;
  assign span_io = (rd && !strap_en) ? (upd ? dac_span[rsel] : in_span[rsel]) : 'z;

  assert_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && clr_n) |=> ($stable(in_code) && $stable(in_span)));

  assert_update_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && clr_n) |=> ($stable(dac_code) && $stable(dac_span)));

  assert_update_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && upd && !$past(upd) && !rd && clr_n && addr == 2'b00 && wr_n && $past(wr_n))
    |=> (dac_code[0] == $past(in_code[0]) && dac_span[0] == $past(in_span[0])));

  assert_clear_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && clr_n && !$past(clr_n) && $stable(span_a) && $stable(span_b))
    |-> (code_a == $past(code_a) && code_b == $past(code_b)));

  assert_span_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (span_a <= LAST_SPAN && span_b <= LAST_SPAN));
endmodule

// File: tb/dual_dac_regs_test.sv
module dual_dac_regs_test;
  logic clk = 0, rst_n = 0, clr_n = 1, wr_n = 1, upd = 0, rd = 0, sel_span = 0;
  logic [1:0] addr = 0;
  logic strap_en = 0;
  logic [2:0] strap_span = 0;
  logic tb_drv = 0;
  logic [15:0] tb_d = 0;
  logic [2:0] tb_s = 0;
  wire [15:0] data_io;
  wire [2:0] span_io;
  logic [15:0] code_a, code_b;
  logic [2:0] span_a, span_b;

  assign data_io = tb_drv ? tb_d : 'z;
  assign span_io = tb_drv ? tb_s : 'z;

  dual_dac_regs uut (.clk, .rst_n, .clr_n, .wr_n, .upd, .rd, .sel_span, .addr,
    .strap_en, .strap_span, .data_io, .span_io, .code_a, .code_b, .span_a, .span_b);

  always #5 clk = ~clk;

  int total = 0, fails = 0;
  logic [15:0] m_in_c [2], m_dac_c [2];
  logic [2:0]  m_in_s [2], m_dac_s [2];

  function automatic logic [2:0] m_norm(input logic [2:0] s);
    return (s > 3'd5) ? 3'd0 : s;
  endfunction
  function automatic logic [15:0] m_zero(input logic [2:0] s);
    case (s)
      3'd2, 3'd3, 3'd4: return 16'h8000;
      3'd5:             return 16'h4000;
      default:          return 16'h0000;
    endcase
  endfunction
  function automatic logic [2:0] m_act(input int c);
    return strap_en ? m_norm(strap_span) : m_norm(m_dac_s[c]);
  endfunction
  function automatic bit m_hit(input int c, input logic [1:0] a);
    return c == 0 ? (a != 2'b01) : (a != 2'b00);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    check(req, code_a, clr_n ? m_dac_c[0] : m_zero(m_act(0)));
    check(req, code_b, clr_n ? m_dac_c[1] : m_zero(m_act(1)));
    check(req, span_a, m_act(0));
    check(req, span_b, m_act(1));
  endtask

  task automatic do_write(input logic [1:0] a, input bit is_span, input logic [15:0] d,
                          input bit with_rd, input bit with_upd);
    @(negedge clk);
    addr = a; sel_span = is_span; rd = with_rd; tb_drv = !with_rd;
    tb_d = d; tb_s = d[2:0]; wr_n = 0;
    @(negedge clk);
    wr_n = 1; upd = with_upd;
    @(negedge clk);
    tb_drv = 0; upd = 0; rd = 0;
    if (!with_rd) begin
      for (int c = 0; c < 2; c++) if (m_hit(c, a)) begin
        if (is_span) begin if (!strap_en) m_in_s[c] = d[2:0]; end
        else m_in_c[c] = d;
        if (with_upd) begin m_dac_c[c] = m_in_c[c]; m_dac_s[c] = m_in_s[c]; end
      end
    end
    chk_out(with_upd ? "R11" : (with_rd ? "R3" : "R2"));
  endtask

  task automatic do_update(input logic [1:0] a);
    @(negedge clk); addr = a; upd = 1;
    @(negedge clk); upd = 0;
    for (int c = 0; c < 2; c++) if (m_hit(c, a)) begin
      m_dac_c[c] = m_in_c[c]; m_dac_s[c] = m_in_s[c];
    end
    chk_out("R4");
  endtask

  task automatic do_read(input logic [1:0] a, input bit bank);
    int c;
    c = (a == 2'b01) ? 1 : 0;
    @(negedge clk); addr = a; upd = bank; rd = 1;
    #2;
    check("R5", data_io, bank ? m_dac_c[c] : m_in_c[c]);
    if (strap_en) check("R10", span_io, 3'bzzz);
    else check("R5", span_io, bank ? m_dac_s[c] : m_in_s[c]);
    @(negedge clk); rd = 0; upd = 0;
    #1;
    check("R6", data_io, 16'hzzzz);
    check("R6", span_io, 3'bzzz);
    chk_out("R5");
  endtask

  task automatic do_clear(input bit with_upd);
    @(negedge clk); clr_n = 0; addr = 2'b10; upd = with_upd;
    #2;
    chk_out("R8");
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      m_in_c[c] = m_zero(m_act(c)); m_dac_c[c] = m_zero(m_act(c));
    end
    clr_n = 1; upd = 0;
    #1;
    chk_out("R9");
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 2; c++) begin m_in_c[c] = 0; m_dac_c[c] = 0; m_in_s[c] = 0; m_dac_s[c] = 0; end
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk_out("R1");
    do_read(2'b00, 0); do_read(2'b01, 1);

    do_write(2'b00, 0, 16'h1234, 0, 0);
    check("R2", code_a, 16'h0000);
    do_write(2'b01, 1, 16'h0003, 0, 0);
    do_read(2'b00, 0); do_read(2'b01, 0); do_read(2'b01, 1);
    do_update(2'b10);
    do_read(2'b11, 1);
    do_write(2'b10, 0, 16'hbeef, 1, 0);
    do_read(2'b00, 0);
    do_write(2'b11, 1, 16'h0006, 0, 1);
    check("R7", span_a, 3'd0);
    do_write(2'b00, 1, 16'h0005, 0, 1);
    do_write(2'b01, 1, 16'h0002, 0, 1);
    do_clear(0);
    check("R8", code_a, 16'h4000);
    check("R8", code_b, 16'h8000);
    do_write(2'b00, 0, 16'h7777, 0, 0);
    do_clear(1);
    do_read(2'b00, 0); do_read(2'b00, 1);

    for (int i = 0; i < 500; i++) begin
      logic [1:0] a; logic [15:0] d;
      a = 2'($urandom_range(0, 3)); d = 16'($urandom);
      case ($urandom_range(0, 7))
        0, 1: do_write(a, 0, d, 0, 0);
        2:    do_write(a, 1, d, 0, 0);
        3:    do_update(a);
        4:    do_read(a, 1'($urandom_range(0, 1)));
        5:    do_write(a, 1'($urandom_range(0, 1)), d, 1, 0);
        6:    do_write(a, 1'($urandom_range(0, 1)), d, 0, 1);
        default: if ($urandom_range(0, 3) == 0) do_clear(1'($urandom_range(0, 1)));
                 else do_read(a, 0);
      endcase
    end

    @(negedge clk); strap_en = 1; strap_span = 3'd5;
    #1; chk_out("R10");
    do_write(2'b10, 1, 16'h0001, 0, 0);
    do_read(2'b00, 1);
    do_clear(0);
    check("R10", code_a, 16'h4000);
    @(negedge clk); strap_en = 0;
    do_read(2'b01, 0);
    do_read(2'b00, 1);

    @(negedge clk); rst_n = 0;
    #1;
    for (int c = 0; c < 2; c++) begin m_in_c[c] = 0; m_dac_c[c] = 0; m_in_s[c] = 0; m_dac_s[c] = 0; end
    @(negedge clk); rst_n = 1;
    #1; chk_out("R1");
    finish_run();
  end
endmodule